// File: doc/BRIEF.md
# Processor Interrupt Cause and Exception Gating

This block holds the four system-control registers that decide whether a processor core breaks its normal flow for an interrupt: the mode/enable word (Status), the pending-cause word (Cause), the saved return address for general exceptions (EPC) and the saved return address for the reset-class event (ErrorEPC). Each cycle it folds in the external interrupt controller's pending and mask vectors, a timer-compare strobe, a hardware-2 strobe and a non-maskable event strobe. From these it updates the pending bits and decides whether to redirect the fetch stream.

When the enable, mode and pending conditions all line up, the block takes a general exception. It saves the current PC, sets the exception-level bit and emits a one-cycle redirect to the general vector. A hardware-2 event forces that exception. A non-maskable event rewrites Status and Cause into their reset form. It saves the PC into ErrorEPC, backed off by one instruction when the core was in a delay slot, and redirects to the reset vector. A register write port lets the core load Status or Cause as an instruction would.

A small state machine produces the redirect. RUN means nothing is being issued. GEN_VEC issues the general vector and RST_VEC issues the reset vector, each for one cycle. The transitions are:
- RUN to GEN_VEC on a take.
- Any state to RST_VEC on a non-maskable event.
- GEN_VEC or RST_VEC to GEN_VEC when another take occurs in that cycle.
- Back to RUN otherwise.

Top module: `cp0_irq_gate`

## Requirements
- R1: After reset, Status, Cause, EPC and ErrorEPC read 0 and redirect_valid is low.
- R2: With wr_en high, wr_sel 0 loads wr_data into Status and wr_sel 1 loads it into Cause. The write is applied before that cycle's event updates, so those updates act on the written value.
- R3: Every cycle, Cause bit 10 is set when (ext_pend & ext_mask) is nonzero and cleared otherwise.
- R4: Whenever bit 10, 12 or 15 of Cause is set by an event, Cause is ANDed with 0xFFFFFF83, which zeros bits 6:2.
- R5: A cmp_evt with cmp_en high sets Cause bit 15. With cmp_en low, the strobe leaves Cause unchanged.
- R6: A general exception is taken only when Status[2:0] is 3'b001 and (Status & Cause & 0x0000FF00) is nonzero. The test uses the Cause and Status values after this cycle's write and event updates.
- R7: Taking a general exception loads EPC with cur_pc, sets Status bit 1, clears Cause bit 31 and issues a redirect to 0x80000180.
- R8: An hw2_evt clears Status bits 21:19, sets Status bit 12 and sets Cause bit 12 with bits 6:2 cleared. It then takes a general exception whatever the take condition.
- R9: An nmi_evt sets Status to (Status & ~0x00380000) | 0x00500004 and zeros Cause. It loads ErrorEPC with cur_pc, or cur_pc - 4 when in_delay_slot is high. It leaves EPC unchanged and redirects to 0xA4000040.
- R10: When nmi_evt and hw2_evt arrive in the same cycle, only the non-maskable effects of R9 occur.
- R11: redirect_valid is high for exactly the one cycle after the edge that takes the event, with redirect_pc holding the target. It returns low when no new event is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 Status, 1 Cause |
| wr_data | input | 32 | Write value |
| ext_pend | input | IRQ_W | External controller pending vector |
| ext_mask | input | IRQ_W | External controller mask vector |
| cmp_evt | input | 1 | Timer-compare event strobe |
| cmp_en | input | 1 | Compare interrupts enabled |
| hw2_evt | input | 1 | Hardware-2 event strobe |
| nmi_evt | input | 1 | Non-maskable event strobe |
| cur_pc | input | 32 | Address of the current instruction |
| in_delay_slot | input | 1 | Current instruction sits in a delay slot |
| status | output | 32 | Status register |
| cause | output | 32 | Cause register |
| epc | output | 32 | General exception return address |
| error_epc | output | 32 | Non-maskable return address |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Redirect target while redirect_valid is high |

## Verification
The embedded assertions check these properties on every cycle:
- An unmasked external request always leaves Cause bit 10 set.
- A non-maskable event always produces a reset-vector pulse with Cause zeroed.
- A hardware-2 event always leaves its Status and Cause bits in place.
- Every general-vector pulse coincides with the exception-level bit being set.

Only the bench's sweeps can show the exact take decision across all low mode values and mask/pending pairings, the code-field clearing, the delay-slot adjustment of ErrorEPC and the precedence of the non-maskable event over hardware-2.

// File: rtl/cp0_gate_pkg.sv
package cp0_gate_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_GEN_VEC = 2'd1,
        ST_RST_VEC = 2'd2
    } vec_state_e;

    localparam logic [31:0] CODE_KEEP = 32'hFFFF_FF83;  // zeros bits 6:2
    localparam logic [31:0] IRQ_FIELD = 32'h0000_FF00;
    localparam logic [31:0] MODE_CLR  = 32'h0038_0000;  // bits 21:19
    localparam logic [31:0] NMI_SET   = 32'h0050_0004;
    localparam int          BIT_EXT   = 10;
    localparam int          BIT_HW2   = 12;
    localparam int          BIT_CMP   = 15;
    localparam int          BIT_EXL   = 1;
    localparam int          BIT_BD    = 31;

endpackage

// File: rtl/cp0_cause_merge.sv
module cp0_cause_merge
    import cp0_gate_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic [31:0]      cause_in,
    input  logic [IRQ_W-1:0] ext_pend,
    input  logic [IRQ_W-1:0] ext_mask,
    input  logic             cmp_hit,
    output logic [31:0]      cause_out
);
    logic ext_hit;

    always_comb begin
        ext_hit   = |(ext_pend & ext_mask);
        cause_out = cause_in;
        if (ext_hit) begin
            cause_out = (cause_out | (32'd1 << BIT_EXT)) & CODE_KEEP;
        end else begin
            cause_out[BIT_EXT] = 1'b0;
        end
        if (cmp_hit) begin
            cause_out = (cause_out | (32'd1 << BIT_CMP)) & CODE_KEEP;
        end
    end

endmodule

// File: rtl/cp0_take_check.sv
module cp0_take_check
    import cp0_gate_pkg::*;
(
    input  logic [31:0] status_in,
    input  logic [31:0] cause_in,
    output logic        take
);
    logic mode_ok;
    logic irq_ok;

    always_comb begin
        mode_ok = (status_in[2:0] == 3'b001);
        irq_ok  = |(status_in & cause_in & IRQ_FIELD);
        take    = mode_ok && irq_ok;
    end

endmodule

// File: rtl/cp0_irq_gate.sv
module cp0_irq_gate
    import cp0_gate_pkg::*;
#(
    parameter int          IRQ_W   = 8,
    parameter logic [31:0] GEN_VEC = 32'h8000_0180,
    parameter logic [31:0] RST_VEC = 32'hA400_0040
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [IRQ_W-1:0] ext_pend,
    input  logic [IRQ_W-1:0] ext_mask,
    input  logic             cmp_evt,
    input  logic             cmp_en,
    input  logic             hw2_evt,
    input  logic             nmi_evt,
    input  logic [31:0]      cur_pc,
    input  logic             in_delay_slot,
    output logic [31:0]      status,
    output logic [31:0]      cause,
    output logic [31:0]      epc,
    output logic [31:0]      error_epc,
    output logic             redirect_valid,
    output logic [31:0]      redirect_pc
);
    localparam logic [31:0] SLOT_STEP = 32'd4;

    vec_state_e  state_q, state_d;
    logic [31:0] status_q, cause_q, epc_q, eepc_q;
    logic [31:0] status_d, cause_d, epc_d, eepc_d;
    logic [31:0] st_w, ca_w, ca_m;
    logic        take_cond;

    // Software write comes first (R2)
    always_comb begin
        st_w = status_q;
        ca_w = cause_q;
        if (wr_en && !wr_sel) st_w = wr_data;
        if (wr_en &&  wr_sel) ca_w = wr_data;
    end

    cp0_cause_merge #(.IRQ_W(IRQ_W)) u_merge (
        .cause_in  (ca_w),
        .ext_pend  (ext_pend),
        .ext_mask  (ext_mask),
        .cmp_hit   (cmp_evt && cmp_en),
        .cause_out (ca_m)
    );

    cp0_take_check u_take (
        .status_in (st_w),
        .cause_in  (ca_m),
        .take      (take_cond)
    );

    // Next-state and register updates
    always_comb begin
        status_d = st_w;
        cause_d  = ca_m;
        epc_d    = epc_q;
        eepc_d   = eepc_q;
        state_d  = ST_RUN;
        if (nmi_evt) begin
            status_d = (st_w & ~MODE_CLR) | NMI_SET;
            cause_d  = 32'd0;
            eepc_d   = in_delay_slot ? (cur_pc - SLOT_STEP) : cur_pc;
            state_d  = ST_RST_VEC;
        end else begin
            if (hw2_evt) begin
                status_d = (st_w & ~MODE_CLR) | (32'd1 << BIT_HW2);
                cause_d  = (ca_m | (32'd1 << BIT_HW2)) & CODE_KEEP;
            end
            if (hw2_evt || take_cond) begin
                epc_d             = cur_pc;
                status_d[BIT_EXL] = 1'b1;
                cause_d[BIT_BD]   = 1'b0;
                state_d           = ST_GEN_VEC;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            status_q <= 32'd0;
            cause_q  <= 32'd0;
            epc_q    <= 32'd0;
            eepc_q   <= 32'd0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
            cause_q  <= cause_d;
            epc_q    <= epc_d;
            eepc_q   <= eepc_d;
        end
    end

    // Outputs
    always_comb begin
        redirect_valid = 1'b0;
        redirect_pc    = 32'd0;
        unique case (state_q)
            ST_RUN: ;
            ST_GEN_VEC: begin
                redirect_valid = 1'b1;
                redirect_pc    = GEN_VEC;
            end
            ST_RST_VEC: begin
                redirect_valid = 1'b1;
                redirect_pc    = RST_VEC;
            end
            default: ;
        endcase
        status    = status_q;
        cause     = cause_q;
        epc       = epc_q;
        error_epc = eepc_q;
    end

    a_r3_ext_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ext_pend & ext_mask)) && !nmi_evt) |=> cause[BIT_EXT]);

    a_r9_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_evt |=> (redirect_valid && redirect_pc == RST_VEC && cause == 32'd0));

    a_r8_hw2_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (hw2_evt && !nmi_evt) |=> (status[BIT_HW2] && cause[BIT_HW2]
                                   && status[21:19] == 3'b000
                                   && redirect_pc == GEN_VEC));

    a_r7_exl_on_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && redirect_pc == GEN_VEC) |-> (status[BIT_EXL] && !cause[BIT_BD]));

    a_r11_quiet_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_evt && !hw2_evt && status[BIT_EXL] && !(wr_en && !wr_sel)) |=> !redirect_valid);

endmodule

// File: tb/tb_cp0_irq_gate.sv
module tb_cp0_irq_gate;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_sel;
    logic [31:0] wr_data;
    logic [7:0]  ext_pend, ext_mask;
    logic        cmp_evt, cmp_en, hw2_evt, nmi_evt;
    logic [31:0] cur_pc;
    logic        in_delay_slot;
    logic [31:0] status, cause, epc, error_epc, redirect_pc;
    logic        redirect_valid;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cp0_irq_gate dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ext_pend(ext_pend), .ext_mask(ext_mask), .cmp_evt(cmp_evt), .cmp_en(cmp_en),
        .hw2_evt(hw2_evt), .nmi_evt(nmi_evt), .cur_pc(cur_pc), .in_delay_slot(in_delay_slot),
        .status(status), .cause(cause), .epc(epc), .error_epc(error_epc),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_sel = 0; wr_data = 0; ext_pend = 0; ext_mask = 0;
        cmp_evt = 0; cmp_en = 0; hw2_evt = 0; nmi_evt = 0; in_delay_slot = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        idle();
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] exp_epc;
        idle();
        cur_pc = 32'h0000_1000;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 status", status, 0);
        chk("R1 cause", cause, 0);
        chk("R1 epc", epc, 0);
        chk("R1 error_epc", error_epc, 0);
        chk("R1 redirect", {31'd0, redirect_valid}, 0);

        // R2/R3/R4 sweep: write Cause with code bits and apply pend/mask same cycle
        for (int sh = 0; sh < 2; sh++) begin
            for (int p = 0; p < 16; p++) begin
                for (int m = 0; m < 16; m++) begin
                    logic [7:0] pv, mv;
                    pv = 8'(p << (4 * sh));
                    mv = 8'(m << (4 * sh));
                    idle();
                    wr_en = 1; wr_sel = 1; wr_data = 32'h0000_047C;
                    ext_pend = pv; ext_mask = mv;
                    tick();
                    chk("R3 R4 R2 ext cause", cause,
                        ((pv & mv) != 0) ? 32'h0000_0400 : 32'h0000_007C);
                end
            end
        end

        // R6/R7/R11 sweep over Status[2:0], IM bits 8/9, pending bits 8/9
        exp_epc = epc;
        for (int s = 0; s < 8; s++) begin
            for (int im = 0; im < 4; im++) begin
                for (int ip = 0; ip < 4; ip++) begin
                    logic [31:0] sv, cv;
                    logic tk;
                    sv = (32'(im) << 8) | 32'(s);
                    cv = 32'h8000_007C | (32'(ip) << 8);
                    tk = (s == 1) && ((im & ip) != 0);
                    wr(0, 32'd0);
                    wr(1, cv);
                    cur_pc = 32'h0000_2000 + 32'((s * 16 + im * 4 + ip) * 4);
                    wr(0, sv);
                    if (tk) exp_epc = cur_pc;
                    chk("R6 take", {31'd0, redirect_valid}, {31'd0, tk});
                    chk("R7 epc", epc, exp_epc);
                    chk("R7 status", status, tk ? (sv | 32'd2) : sv);
                    chk("R7 cause", cause, tk ? (cv & 32'h7FFF_FFFF) : cv);
                    if (tk) chk("R7 vector", redirect_pc, 32'h8000_0180);
                    idle(); tick();
                    chk("R11 pulse ends", {31'd0, redirect_valid}, 0);
                end
            end
        end

        // R5 compare enabled and disabled
        wr(0, 32'd0);
        wr(1, 32'h0000_007C);
        idle(); cmp_evt = 1; cmp_en = 0; tick();
        chk("R5 cmp disabled", cause, 32'h0000_007C);
        idle(); cmp_evt = 1; cmp_en = 1; tick();
        chk("R5 cmp enabled", cause, 32'h0000_8000);
        chk("R5 no take", {31'd0, redirect_valid}, 0);
        wr(1, 32'h0000_007C);
        idle(); wr_en = 1; wr_sel = 0; wr_data = 32'h0000_8001;
        cmp_evt = 1; cmp_en = 1; cur_pc = 32'h0000_3000; tick();
        chk("R5 R6 cmp take", {31'd0, redirect_valid}, 1);
        chk("R5 R7 epc", epc, 32'h0000_3000);

        // R8 hw2 forced take even with exception level already set
        wr(0, 32'h0038_0003);
        wr(1, 32'h0000_007C);
        idle(); hw2_evt = 1; cur_pc = 32'h0000_4000; tick();
        chk("R8 status", status, 32'h0000_1003);
        chk("R8 cause", cause, 32'h0000_1000);
        chk("R8 epc", epc, 32'h0000_4000);
        chk("R8 vector", redirect_pc, 32'h8000_0180);
        chk("R8 valid", {31'd0, redirect_valid}, 1);

        // R9 NMI outside and inside delay slot
        for (int ds = 0; ds < 2; ds++) begin
            wr(0, 32'h0038_0001);
            wr(1, 32'h0000_9400);
            idle(); nmi_evt = 1; in_delay_slot = ds[0];
            cur_pc = 32'h0000_5000 + 32'(ds * 32'h100); tick();
            chk("R9 status", status, 32'h0050_0005);
            chk("R9 cause", cause, 0);
            chk("R9 error_epc", error_epc, cur_pc - (ds[0] ? 32'd4 : 32'd0));
            chk("R9 epc kept", epc, 32'h0000_4000);
            chk("R9 vector", redirect_pc, 32'hA400_0040);
            idle(); tick();
            chk("R11 nmi pulse ends", {31'd0, redirect_valid}, 0);
        end

        // R10 NMI beats hw2
        wr(0, 32'h0000_0001);
        idle(); nmi_evt = 1; hw2_evt = 1; cur_pc = 32'h0000_6000; tick();
        chk("R10 vector", redirect_pc, 32'hA400_0040);
        chk("R10 status", status, 32'h0050_0005);
        chk("R10 cause", cause, 0);
        chk("R10 epc kept", epc, 32'h0000_4000);
        chk("R10 error_epc", error_epc, 32'h0000_6000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule